// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block watches the write bus cycles sent to a parallel NOR-style flash array. It turns the multi-cycle unlock and command sequences into single-cycle operation strobes for the array controller. Each write is classified by its low command byte and by the low address bits used for unlock matching. A sequencer then follows the standard two-unlock-write flows, the shortened flows of unlock-bypass mode, and the sticky identification and query modes. Erase suspend and erase resume are gated by the erase status that the array controller reports.

A write that is accepted as the last step of an operation raises that operation's strobe for one clock, in the cycle after the write. In the same cycle the write's address, data, bank and sector appear on registered outputs. These outputs change only when a strobe fires. A write that breaks a sequence is dropped without a strobe.

Top module: `fcd_decoder`

## Requirements
- R1: After reset every strobe is low, the latched address, data, bank and sector outputs are zero, and the decoder is in its idle state with no suspend pending.
- R2: Writes of AA to 555, 55 to 2AA and A0 to 555, followed by a write to any address, raise the program strobe. The fourth write's address and data are latched. The fourth write is always taken as program data, even when its low byte is F0.
- R3: Six writes (unlock, 80 at 555, unlock, then 10 at 555) raise the chip-erase strobe. When the last write is instead 30 to any address, the sector-erase strobe rises, and the sector output holds address bits 20 to 13 of that write.
- R4: A write that is not the expected next step of a standard sequence discards the partial sequence and returns the decoder to idle without any strobe.
- R5: Outside bypass mode and outside the program-data step, a write with low byte F0 to any address raises the read-reset strobe and returns the decoder to idle, including from the middle of a sequence.
- R6: The unlock writes followed by 90 at 555 raise the autoselect strobe, with the bank output equal to address bits 20 to 19. The decoder then ignores every write except F0 (reset) and 98 to 55 (query entry).
- R7: The unlock writes followed by C0 at 555 raise the configuration-write strobe. The latched address carries the register value on bits 19 to 12.
- R8: From idle, a single write of 98 to address 55 raises the query strobe. Query mode ignores every write except F0.
- R9: The unlock writes followed by 20 at 555 enter bypass mode without a strobe. In bypass mode, A0 followed by a write gives program, 80 then 30 gives sector erase, and 80 then 10 gives chip erase. Writes of F0 and unlock writes have no effect there.
- R10: Bypass mode is left only by 90 followed by 00, which raises the read-reset strobe and returns to idle. A 90 followed by any other byte stays in bypass mode.
- R11: Data bits 15 to 8 are ignored when command bytes are matched. The 555, 2AA and 55 address checks compare only address bits 10 to 0.
- R12: B0 raises the suspend strobe only from idle or bypass-idle, only while the erase-busy input is high, and only when no suspend is pending. 30 at such a point raises the resume strobe only while a suspend is pending. A pending suspend clears on resume or when erase-busy is low.
- R13: Each strobe lasts one clock, at most one strobe is high in a cycle, strobes follow only a valid write, and the latched outputs hold their values in every cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | A bus write is presented this cycle |
| wr_addr | input | 21 | Word address of the write |
| wr_data | input | 16 | Data of the write |
| erase_busy | input | 1 | Array controller has a sector erase in progress |
| stb_rst | output | 1 | Read-reset strobe |
| stb_prog | output | 1 | Program strobe |
| stb_sec | output | 1 | Sector-erase strobe |
| stb_chip | output | 1 | Chip-erase strobe |
| stb_asel | output | 1 | Autoselect-entry strobe |
| stb_cfg | output | 1 | Configuration-register write strobe |
| stb_qry | output | 1 | Query-entry strobe |
| stb_sus | output | 1 | Erase-suspend strobe |
| stb_res | output | 1 | Erase-resume strobe |
| op_addr | output | 21 | Address of the write that raised the last strobe |
| op_data | output | 16 | Data of the write that raised the last strobe |
| op_bank | output | 2 | Bank bits of op_addr |
| op_sector | output | 8 | Sector bits of op_addr |

## Verification
The assertions check on every cycle that at most one strobe is high, that a strobe always follows a valid write, and that the latched outputs stay stable between strobes. They also check that program and chip-erase strobes come only from the matching sequence steps, that bypass mode and query mode can be left only by their allowed paths, and that suspend and resume respect the erase state. Only the bench scenarios can show that whole sequences decode to the right operation with the right latched fields. The same applies to broken sequences leaving no trace, to the stickiness of the identification modes against later unlock writes, to the masking of high data and address bits, and to the exact cycle at which each strobe appears.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  localparam int NUM_OPS = 9;

  localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
  localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
  localparam logic [7:0] CMD_RESET    = 8'hF0;
  localparam logic [7:0] CMD_PROG     = 8'hA0;
  localparam logic [7:0] CMD_ERASE    = 8'h80;
  localparam logic [7:0] CMD_CHIP     = 8'h10;
  localparam logic [7:0] CMD_SECT     = 8'h30;
  localparam logic [7:0] CMD_BYPASS   = 8'h20;
  localparam logic [7:0] CMD_IDENT    = 8'h90;
  localparam logic [7:0] CMD_CFG      = 8'hC0;
  localparam logic [7:0] CMD_QUERY    = 8'h98;
  localparam logic [7:0] CMD_SUSPEND  = 8'hB0;
  localparam logic [7:0] CMD_RESUME   = 8'h30;
  localparam logic [7:0] CMD_BYP_EXIT = 8'h00;

  typedef enum logic [3:0] {
    OP_NONE = 4'd0,
    OP_RST  = 4'd1,
    OP_PROG = 4'd2,
    OP_SEC  = 4'd3,
    OP_CHIP = 4'd4,
    OP_ASEL = 4'd5,
    OP_CFG  = 4'd6,
    OP_QRY  = 4'd7,
    OP_SUS  = 4'd8,
    OP_RES  = 4'd9
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_U1, S_U2, S_PRG, S_E1, S_E2, S_E3,
    S_ASEL, S_QRY, S_BYP, S_BPRG, S_BERS, S_BRST
  } st_e;

  typedef struct packed {
    logic       at_555;
    logic       at_2aa;
    logic       at_055;
    logic [7:0] code;
  } wr_class_t;

  // States in which the decoder sits inside bypass mode
  function automatic logic in_bypass(input st_e s);
    return (s == S_BYP) || (s == S_BPRG) || (s == S_BERS) || (s == S_BRST);
  endfunction

  // States in which F0 is not a reset (bypass or the program-data step)
  function automatic logic reset_masked(input st_e s);
    return in_bypass(s) || (s == S_PRG);
  endfunction

  // One-hot strobe vector for an operation; bit k is operation k+1
  function automatic logic [NUM_OPS-1:0] op_onehot(input op_e op);
    logic [NUM_OPS-1:0] v;
    v = '0;
    if (op != OP_NONE) v[int'(op) - 1] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/fcd_classify.sv
module fcd_classify
  import fcd_pkg::*;
#(
  parameter int UNLOCK_W = 11
) (
  input  logic [UNLOCK_W-1:0] addr_lo,
  input  logic [7:0]          code_in,
  output wr_class_t           cls
);
  localparam logic [UNLOCK_W-1:0] PAT_555 = UNLOCK_W'(11'h555);
  localparam logic [UNLOCK_W-1:0] PAT_2AA = UNLOCK_W'(11'h2AA);
  localparam logic [UNLOCK_W-1:0] PAT_055 = UNLOCK_W'(11'h055);

  always_comb begin
    cls.at_555 = (addr_lo == PAT_555);
    cls.at_2aa = (addr_lo == PAT_2AA);
    cls.at_055 = (addr_lo == PAT_055);
    cls.code   = code_in;
  end
endmodule

// File: rtl/fcd_susp.sv
module fcd_susp (
  input  logic clk,
  input  logic rst_n,
  input  logic erase_busy,
  input  logic sus_fire,
  input  logic res_fire,
  output logic allow_sus,
  output logic allow_res
);
  logic susp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          susp_q <= 1'b0;
    else if (!erase_busy) susp_q <= 1'b0;
    else if (sus_fire)    susp_q <= 1'b1;
    else if (res_fire)    susp_q <= 1'b0;
  end

  assign allow_sus = erase_busy & ~susp_q;
  assign allow_res = susp_q;

  AST_SUS_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    sus_fire |-> (erase_busy && !susp_q)); // R12
  AST_RES_ONLY_SUSPENDED: assert property (@(posedge clk) disable iff (!rst_n)
    res_fire |-> susp_q); // R12
  AST_SUSP_CLEARS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !erase_busy |=> !susp_q); // R12
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_valid,
  input  wr_class_t cls,
  input  logic      allow_sus,
  input  logic      allow_res,
  output op_e       op,
  output st_e       state
);
  st_e  nxt;
  logic [7:0] c;

  assign c = cls.code;

  always_comb begin
    nxt = state;
    op  = OP_NONE;
    if (wr_valid) begin
      if (!reset_masked(state) && (c == CMD_RESET)) begin
        op  = OP_RST;
        nxt = S_IDLE;
      end else begin
        unique case (state)
          S_IDLE: begin
            if (cls.at_555 && c == CMD_UNLOCK_A)       nxt = S_U1;
            else if (cls.at_055 && c == CMD_QUERY) begin op = OP_QRY; nxt = S_QRY; end
            else if (c == CMD_SUSPEND && allow_sus)      op = OP_SUS;
            else if (c == CMD_RESUME && allow_res)       op = OP_RES;
          end
          S_U1: nxt = (cls.at_2aa && c == CMD_UNLOCK_B) ? S_U2 : S_IDLE;
          S_U2: begin
            nxt = S_IDLE;
            if (cls.at_555) begin
              case (c)
                CMD_PROG:   nxt = S_PRG;
                CMD_ERASE:  nxt = S_E1;
                CMD_BYPASS: nxt = S_BYP;
                CMD_IDENT:  begin op = OP_ASEL; nxt = S_ASEL; end
                CMD_CFG:    op = OP_CFG;
                default:    nxt = S_IDLE;
              endcase
            end
          end
          S_PRG: begin op = OP_PROG; nxt = S_IDLE; end
          S_E1: nxt = (cls.at_555 && c == CMD_UNLOCK_A) ? S_E2 : S_IDLE;
          S_E2: nxt = (cls.at_2aa && c == CMD_UNLOCK_B) ? S_E3 : S_IDLE;
          S_E3: begin
            nxt = S_IDLE;
            if (cls.at_555 && c == CMD_CHIP) op = OP_CHIP;
            else if (c == CMD_SECT)          op = OP_SEC;
          end
          S_ASEL: begin
            if (cls.at_055 && c == CMD_QUERY) begin op = OP_QRY; nxt = S_QRY; end
          end
          S_QRY: nxt = S_QRY;
          S_BYP: begin
            if (c == CMD_PROG)                        nxt = S_BPRG;
            else if (c == CMD_ERASE)                  nxt = S_BERS;
            else if (c == CMD_IDENT)                  nxt = S_BRST;
            else if (c == CMD_SUSPEND && allow_sus)   op = OP_SUS;
            else if (c == CMD_RESUME && allow_res)    op = OP_RES;
          end
          S_BPRG: begin op = OP_PROG; nxt = S_BYP; end
          S_BERS: begin
            nxt = S_BYP;
            if (c == CMD_SECT)      op = OP_SEC;
            else if (c == CMD_CHIP) op = OP_CHIP;
          end
          S_BRST: begin
            if (c == CMD_BYP_EXIT) begin op = OP_RST; nxt = S_IDLE; end
            else                   nxt = S_BYP;
          end
          default: nxt = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end

  AST_BYP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bypass($past(state)) && $past(state) != S_BRST) |-> in_bypass(state)); // R10
  AST_QRY_EXIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == S_QRY && state != S_QRY) |-> (state == S_IDLE)); // R8
endmodule

// File: rtl/fcd_decoder.sv
module fcd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 16,
  parameter int UNLOCK_W = 11,
  parameter int BANK_W   = 2,
  parameter int SECT_LSB = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              erase_busy,
  output logic              stb_rst,
  output logic              stb_prog,
  output logic              stb_sec,
  output logic              stb_chip,
  output logic              stb_asel,
  output logic              stb_cfg,
  output logic              stb_qry,
  output logic              stb_sus,
  output logic              stb_res,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic [BANK_W-1:0] op_bank,
  output logic [ADDR_W-SECT_LSB-1:0] op_sector
);
  localparam int SECT_W = ADDR_W - SECT_LSB;

  wr_class_t cls;
  op_e       op;
  st_e       seq_state;
  logic      allow_sus, allow_res;
  logic      sus_fire, res_fire;
  logic [NUM_OPS-1:0] op_vec;
  logic [NUM_OPS-1:0] stb_q;

  fcd_classify #(.UNLOCK_W(UNLOCK_W)) u_cls (
    .addr_lo (wr_addr[UNLOCK_W-1:0]),
    .code_in (wr_data[7:0]),
    .cls     (cls)
  );

  fcd_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .cls       (cls),
    .allow_sus (allow_sus),
    .allow_res (allow_res),
    .op        (op),
    .state     (seq_state)
  );

  assign sus_fire = (op == OP_SUS);
  assign res_fire = (op == OP_RES);

  fcd_susp u_susp (
    .clk        (clk),
    .rst_n      (rst_n),
    .erase_busy (erase_busy),
    .sus_fire   (sus_fire),
    .res_fire   (res_fire),
    .allow_sus  (allow_sus),
    .allow_res  (allow_res)
  );

  assign op_vec = op_onehot(op);

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_stb
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_q[i] <= 1'b0;
      else        stb_q[i] <= op_vec[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_addr   <= '0;
      op_data   <= '0;
      op_bank   <= '0;
      op_sector <= '0;
    end else if (op != OP_NONE) begin
      op_addr   <= wr_addr;
      op_data   <= wr_data;
      op_bank   <= wr_addr[ADDR_W-1 -: BANK_W];
      op_sector <= wr_addr[ADDR_W-1 -: SECT_W];
    end
  end

  assign stb_rst  = stb_q[0];
  assign stb_prog = stb_q[1];
  assign stb_sec  = stb_q[2];
  assign stb_chip = stb_q[3];
  assign stb_asel = stb_q[4];
  assign stb_cfg  = stb_q[5];
  assign stb_qry  = stb_q[6];
  assign stb_sus  = stb_q[7];
  assign stb_res  = stb_q[8];

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb_q)); // R13
  AST_STROBE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_q != '0) |-> $past(wr_valid)); // R13
  AST_OPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_q == '0) |-> ($stable(op_addr) && $stable(op_data))); // R13
  AST_PROG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_prog |-> ($past(seq_state) == S_PRG || $past(seq_state) == S_BPRG)); // R2
  AST_CHIP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_chip |-> ($past(seq_state) == S_E3 || $past(seq_state) == S_BERS)); // R3
  AST_SUS_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    stb_sus |-> $past(erase_busy)); // R12
endmodule

// File: tb/sim_fcd_decoder.sv
`timescale 1ns/1ps
module sim_fcd_decoder;
  localparam int K_RST = 0, K_PRG = 1, K_SEC = 2, K_CHP = 3, K_ASL = 4,
                 K_CFG = 5, K_QRY = 6, K_SUS = 7, K_RES = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [20:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic erase_busy = 1'b0;
  logic stb_rst, stb_prog, stb_sec, stb_chip, stb_asel, stb_cfg, stb_qry, stb_sus, stb_res;
  logic [20:0] op_addr;
  logic [15:0] op_data;
  logic [1:0]  op_bank;
  logic [7:0]  op_sector;

  fcd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .erase_busy(erase_busy),
    .stb_rst(stb_rst), .stb_prog(stb_prog), .stb_sec(stb_sec), .stb_chip(stb_chip),
    .stb_asel(stb_asel), .stb_cfg(stb_cfg), .stb_qry(stb_qry), .stb_sus(stb_sus),
    .stb_res(stb_res), .op_addr(op_addr), .op_data(op_data), .op_bank(op_bank),
    .op_sector(op_sector)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit busy_req = 0;
  string cur_tag = "R1";

  // reference model state
  logic [20:0] qa[$];
  logic [15:0] qd[$];
  bit in_byp = 0;
  int info = 0;           // 0 none, 1 identification, 2 query
  bit susp = 0;
  logic [8:0]  exp_stb = '0;
  logic [20:0] exp_addr = '0;
  logic [15:0] exp_data = '0;

  function automatic bit lo(input logic [20:0] a, input logic [10:0] v);
    return a[10:0] == v;
  endfunction

  task automatic model_step(input bit v, input logic [20:0] a, input logic [15:0] d);
    int fire = -1;
    logic [7:0] c = d[7:0];
    exp_stb = '0;
    if (v) begin
      if (info != 0) begin
        if (c == 8'hF0) begin fire = K_RST; info = 0; end
        else if (info == 1 && c == 8'h98 && lo(a, 11'h055)) begin fire = K_QRY; info = 2; end
      end else if (in_byp) begin
        qa.push_back(a); qd.push_back(d);
        if (qd.size() == 1) begin
          if (!(c inside {8'hA0, 8'h80, 8'h90})) begin
            if (c == 8'hB0 && busy_req && !susp) fire = K_SUS;
            else if (c == 8'h30 && susp) fire = K_RES;
            qa.delete(); qd.delete();
          end
        end else begin
          if (qd[0][7:0] == 8'hA0) fire = K_PRG;
          else if (qd[0][7:0] == 8'h80) begin
            if (c == 8'h30) fire = K_SEC; else if (c == 8'h10) fire = K_CHP;
          end else if (c == 8'h00) begin fire = K_RST; in_byp = 0; end
          qa.delete(); qd.delete();
        end
      end else begin
        bit pdata = (qd.size() == 3) && (qd[2][7:0] == 8'hA0);
        if (c == 8'hF0 && !pdata) begin
          fire = K_RST; qa.delete(); qd.delete();
        end else begin
          bit keep = 0;
          qa.push_back(a); qd.push_back(d);
          case (qd.size())
            1: begin
              keep = lo(a, 11'h555) && c == 8'hAA;
              if (!keep) begin
                if (c == 8'h98 && lo(a, 11'h055)) begin fire = K_QRY; info = 2; end
                else if (c == 8'hB0 && busy_req && !susp) fire = K_SUS;
                else if (c == 8'h30 && susp) fire = K_RES;
              end
            end
            2: keep = lo(a, 11'h2AA) && c == 8'h55;
            3: if (lo(a, 11'h555)) begin
                 if (c == 8'hA0 || c == 8'h80) keep = 1;
                 else if (c == 8'h20) in_byp = 1;
                 else if (c == 8'h90) begin fire = K_ASL; info = 1; end
                 else if (c == 8'hC0) fire = K_CFG;
               end
            4: if (qd[2][7:0] == 8'hA0) fire = K_PRG;
               else keep = lo(a, 11'h555) && c == 8'hAA;
            5: keep = lo(a, 11'h2AA) && c == 8'h55;
            default: begin
              if (lo(a, 11'h555) && c == 8'h10) fire = K_CHP;
              else if (c == 8'h30) fire = K_SEC;
            end
          endcase
          if (!keep) begin qa.delete(); qd.delete(); end
        end
      end
    end
    if (fire >= 0) begin
      exp_stb[fire] = 1'b1;
      exp_addr = a;
      exp_data = d;
    end
    if (!busy_req) susp = 0;
    else if (fire == K_SUS) susp = 1;
    else if (fire == K_RES) susp = 0;
  endtask

  task automatic check_outputs();
    logic [8:0] act;
    act = {stb_res, stb_sus, stb_qry, stb_cfg, stb_asel, stb_chip, stb_sec, stb_prog, stb_rst};
    checks++;
    if (act !== exp_stb) begin
      errors++;
      $display("FAIL %s strobes actual=%b expected=%b", cur_tag, act, exp_stb);
    end
    checks++;
    if ({op_addr, op_data, op_bank, op_sector} !==
        {exp_addr, exp_data, exp_addr[20:19], exp_addr[20:13]}) begin
      errors++;
      $display("FAIL %s fields actual=%h/%h/%h/%h expected=%h/%h/%h/%h", cur_tag,
               op_addr, op_data, op_bank, op_sector,
               exp_addr, exp_data, exp_addr[20:19], exp_addr[20:13]);
    end
  endtask

  // one clock: check previous result, drive this cycle, predict next
  task automatic cyc(input bit v, input logic [20:0] a, input logic [15:0] d, input string tag);
    @(negedge clk);
    check_outputs();
    wr_valid = v; wr_addr = a; wr_data = d; erase_busy = busy_req;
    model_step(v, a, d);
    cur_tag = tag;
  endtask

  task automatic w(input logic [20:0] a, input logic [15:0] d, input string tag);
    cyc(1'b1, a, d, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 21'h0, 16'h0, tag);
  endtask

  task automatic unlock(input string tag);
    w(21'h000555, 16'h00AA, tag);
    w(21'h0002AA, 16'h0055, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2, "R1");

    // R2 program, with junk high bits (R11)
    w(21'h1F0555, 16'h12AA, "R11"); w(21'h0A82AA, 16'h3455, "R11");
    w(21'h000555, 16'hFFA0, "R2");  w(21'h12345A, 16'hBEEF, "R2");
    idle(2, "R2");
    unlock("R2"); w(21'h000555, 16'h00A0, "R2"); w(21'h0C0101, 16'h00F0, "R2");
    idle(1, "R2");

    // R3 chip and sector erase
    unlock("R3"); w(21'h000555, 16'h0080, "R3"); unlock("R3"); w(21'h000555, 16'h0010, "R3");
    idle(1, "R3");
    unlock("R3"); w(21'h000555, 16'h0080, "R3"); unlock("R3"); w(21'h1A2000, 16'h0030, "R3");
    idle(1, "R3");

    // R4 broken sequences
    w(21'h000555, 16'h00AA, "R4"); w(21'h0002AB, 16'h0055, "R4"); w(21'h000555, 16'h00A0, "R4");
    w(21'h000777, 16'h0011, "R4");
    unlock("R4"); w(21'h000555, 16'h0077, "R4"); w(21'h000555, 16'h0010, "R4");
    unlock("R4"); w(21'h000555, 16'h0080, "R4"); w(21'h000556, 16'h00AA, "R4");
    w(21'h0002AA, 16'h0055, "R4"); w(21'h000555, 16'h0010, "R4");
    idle(1, "R4");

    // R5 reset mid-sequence
    w(21'h000555, 16'h00AA, "R5"); w(21'h000123, 16'h77F0, "R5"); w(21'h000555, 16'h00A0, "R5");
    unlock("R5"); w(21'h000555, 16'h0080, "R5"); w(21'h000000, 16'h00F0, "R5");
    idle(1, "R5");

    // R6 autoselect, sticky, then query and reset
    unlock("R6"); w(21'h0C0555, 16'h0090, "R6");
    unlock("R6"); w(21'h000555, 16'h00A0, "R6"); w(21'h000010, 16'h1234, "R6");
    w(21'h100055, 16'h0098, "R6");
    unlock("R6"); w(21'h000555, 16'h0090, "R6");
    w(21'h000000, 16'h00F0, "R6");
    idle(1, "R6");

    // R7 configuration write
    unlock("R7"); w(21'h05A555, 16'h00C0, "R7");
    idle(1, "R7");

    // R8 query entry from idle, sticky
    w(21'h000055, 16'h0098, "R8");
    unlock("R8"); w(21'h000555, 16'h0090, "R8"); w(21'h000055, 16'h0098, "R8");
    w(21'h000004, 16'h00F0, "R8");
    idle(1, "R8");

    // R9 bypass mode
    unlock("R9"); w(21'h000555, 16'h0020, "R9");
    w(21'h000000, 16'h00A0, "R9"); w(21'h0ABCDE, 16'h5A5A, "R9");
    w(21'h000000, 16'h00A0, "R9"); w(21'h000001, 16'h00F0, "R9");
    w(21'h000000, 16'h0080, "R9"); w(21'h1FE000, 16'h0030, "R9");
    w(21'h000000, 16'h0080, "R9"); w(21'h000000, 16'h0010, "R9");
    w(21'h000000, 16'h00F0, "R9");
    unlock("R9"); w(21'h000555, 16'h0090, "R9"); w(21'h000000, 16'h0011, "R9");
    w(21'h000000, 16'h00A0, "R9"); w(21'h000042, 16'h0042, "R9");

    // R10 bypass exit
    w(21'h180000, 16'h0090, "R10"); w(21'h000000, 16'h0000, "R10");
    w(21'h000000, 16'h00A0, "R10"); w(21'h000043, 16'h0043, "R10");
    idle(1, "R10");

    // R12 suspend / resume
    w(21'h080000, 16'h00B0, "R12"); w(21'h080000, 16'h0030, "R12");
    busy_req = 1;
    idle(1, "R12");
    w(21'h080000, 16'h00B0, "R12"); w(21'h080000, 16'h00B0, "R12");
    w(21'h080000, 16'h0030, "R12"); w(21'h080000, 16'h0030, "R12");
    w(21'h100000, 16'h00B0, "R12");
    busy_req = 0;
    idle(1, "R12");
    w(21'h100000, 16'h0030, "R12");
    busy_req = 1;
    unlock("R12"); w(21'h000555, 16'h0020, "R12");
    w(21'h000000, 16'h00B0, "R12"); w(21'h000000, 16'h0030, "R12");
    w(21'h000000, 16'h0090, "R12"); w(21'h000000, 16'h0000, "R12");
    busy_req = 0;

    // R13 back-to-back resets and quiet gaps
    w(21'h000000, 16'h00F0, "R13"); w(21'h000001, 16'h00F0, "R13");
    idle(3, "R13");

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL R13 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule